// File: doc/BRIEF.md
# DRAM Row Boundary Decoder

This block decides which of eight DRAM rows serves a physical address. Software programs one byte per row holding the running total of installed memory, counted in 8 MB units, from row 0 up to and including that row. Row i therefore covers the span that starts where row i-1 ends and stops just short of its own total. A row whose total matches the total before it holds no memory and is never chosen.

Two fixed windows can be carved out of memory: a small one just below the 640 KB line and a 1 MB one just below 16 MB. When the selected window contains the lookup address, the block raises a hole flag so that the access is forwarded elsewhere, and it withholds both the row select and the DRAM hit. A lookup presented with a request strobe returns its row select, DRAM hit and hole flag one clock later.

Top module: `rowbnd_decoder`

## Requirements
- R1: After reset every boundary register is 0 and the window code is 00. All outputs are low, and no lookup asserts dram_hit until a boundary is written.
- R2: A write with wr_addr 0 to 7 loads boundary register wr_addr from wr_data. A write with wr_addr 8 loads the window code from wr_data[1:0]. Writes to wr_addr 9 to 15 change nothing. A lookup presented in the same cycle as a write uses the values from before the write. The next lookup uses the new values.
- R3: With U = req_addr >> 23, row i is selected (row_sel bit i) when B[i-1] <= U < B[i], where B[i] is boundary register i and B[-1] is 0.
- R4: A row whose boundary equals the previous boundary is never selected, and addresses past it fall into the next non-empty row.
- R5: An address with U at or above every boundary returns row_sel 0 and dram_hit 0.
- R6: row_sel has at most one bit set, and dram_hit is 1 exactly when one bit is set. If unordered boundaries make several row ranges contain U, the lowest-numbered row wins.
- R7: Window code 01 covers addresses 0x80000 to 0x9FFFF. Inside it, hole_hit is 1 and both row_sel and dram_hit are 0.
- R8: Window code 10 covers addresses 0xF00000 to 0xFFFFFF. Inside it, hole_hit is 1 and both row_sel and dram_hit are 0.
- R9: Window codes 00 and 11 open no window, so hole_hit stays 0 and the row decode applies everywhere.
- R10: A lookup strobed with req_vld in one cycle gives rsp_vld and its results in the next cycle. rsp_vld is low in a cycle that follows no request.
- R11: With all eight boundaries at 0x08, addresses 0 to 0x3FFFFFF select row 0 and higher addresses hit no row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register index: 0-7 boundaries, 8 window code |
| wr_data | input | 8 | Write data |
| req_vld | input | 1 | Lookup strobe |
| req_addr | input | 32 | Physical address to decode |
| rsp_vld | output | 1 | Lookup result valid |
| row_sel | output | 8 | One-hot selected row |
| dram_hit | output | 1 | Address is served by a DRAM row |
| hole_hit | output | 1 | Address lies in the enabled fixed window |

## Verification
Lookups are run against several boundary layouts. A single-module layout with all boundaries equal separates row 0 from the unpopulated space above it. A staggered layout with empty rows exercises the first and last address of every populated row and shows whether empty rows are skipped. A deliberately unordered layout shows whether the lowest row wins on overlap. Each window code is tried at the inner and outer edges of both windows. Back-to-back lookups, lookups issued in the same cycle as a write, and writes to unused indices show whether the one-cycle latency holds, whether the old values are used, and whether unused indices are truly ignored.

// File: rtl/rowbnd_pkg.sv
`timescale 1ns/1ps
package rowbnd_pkg;

   // Fixed-window selector; the code value is what software writes
   typedef enum logic [1:0] {
      HOLE_NONE = 2'b00,
      HOLE_LOW  = 2'b01,
      HOLE_HIGH = 2'b10,
      HOLE_RSVD = 2'b11
   } hole_mode_e;

   localparam int HOLE_CODE_W = 2;

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/rowbnd_regs.sv
`timescale 1ns/1ps
module rowbnd_regs
   import rowbnd_pkg::*;
#(
   parameter int NUM_ROWS = 8,
   parameter int BND_W    = 8,
   parameter int SEL_W    = $clog2(NUM_ROWS) + 1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  logic [SEL_W-1:0]                wr_addr,
   input  logic [BND_W-1:0]                wr_data,
   output logic [NUM_ROWS-1:0][BND_W-1:0]  bnd_o,
   output hole_mode_e                      hole_o
);

   localparam int IDX_W = $clog2(NUM_ROWS);
   localparam logic [SEL_W-1:0] HOLE_IDX = SEL_W'(NUM_ROWS);

   logic [NUM_ROWS-1:0][BND_W-1:0] bnd_q;
   hole_mode_e                     hole_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bnd_q  <= '0;
         hole_q <= HOLE_NONE;
      end else if (wr_en) begin
         if (!wr_addr[SEL_W-1]) begin
            bnd_q[wr_addr[IDX_W-1:0]] <= wr_data;
         end else if (wr_addr == HOLE_IDX) begin
            hole_q <= hole_mode_e'(wr_data[HOLE_CODE_W-1:0]);
         end
      end
   end

   assign bnd_o  = bnd_q;
   assign hole_o = hole_q;

endmodule

// File: rtl/rowbnd_match.sv
`timescale 1ns/1ps
module rowbnd_match
   import rowbnd_pkg::*;
#(
   parameter int NUM_ROWS = 8,
   parameter int BND_W    = 8,
   parameter int UNIT_W   = 9
) (
   input  logic [UNIT_W-1:0]               unit_i,
   input  logic [NUM_ROWS-1:0][BND_W-1:0]  bnd_i,
   output logic [NUM_ROWS-1:0]             sel_o,
   output logic                            any_o
);

   localparam int CMP_W = max_int(UNIT_W, BND_W);

   logic [CMP_W-1:0]    unit_x;
   logic [NUM_ROWS-1:0] in_row;

   assign unit_x = CMP_W'(unit_i);

   for (genvar g = 0; g < NUM_ROWS; g++) begin : g_row
      logic [CMP_W-1:0] lo_x;
      logic [CMP_W-1:0] hi_x;
      if (g == 0) begin : g_first
         assign lo_x = '0;
      end else begin : g_rest
         assign lo_x = CMP_W'(bnd_i[g-1]);
      end
      assign hi_x      = CMP_W'(bnd_i[g]);
      assign in_row[g] = (unit_x >= lo_x) && (unit_x < hi_x);
   end

   // isolate the lowest candidate row so overlaps stay one-hot
   assign sel_o = in_row & (~in_row + NUM_ROWS'(1));
   assign any_o = |in_row;

endmodule

// File: rtl/rowbnd_hole.sv
`timescale 1ns/1ps
module rowbnd_hole
   import rowbnd_pkg::*;
#(
   parameter int              ADDR_W  = 32,
   parameter longint unsigned LO_BASE = 64'h0008_0000,
   parameter longint unsigned LO_END  = 64'h000A_0000,
   parameter longint unsigned HI_BASE = 64'h00F0_0000,
   parameter longint unsigned HI_END  = 64'h0100_0000
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  hole_mode_e        mode_i,
   output logic              in_hole_o
);

   localparam logic [ADDR_W-1:0] LB = ADDR_W'(LO_BASE);
   localparam logic [ADDR_W-1:0] LE = ADDR_W'(LO_END);
   localparam logic [ADDR_W-1:0] HB = ADDR_W'(HI_BASE);
   localparam logic [ADDR_W-1:0] HE = ADDR_W'(HI_END);

   always_comb begin
      unique case (mode_i)
         HOLE_LOW:  in_hole_o = (addr_i >= LB) && (addr_i < LE);
         HOLE_HIGH: in_hole_o = (addr_i >= HB) && (addr_i < HE);
         default:   in_hole_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/rowbnd_decoder.sv
`timescale 1ns/1ps
module rowbnd_decoder
   import rowbnd_pkg::*;
#(
   parameter int              NUM_ROWS   = 8,
   parameter int              BND_W      = 8,
   parameter int              ADDR_W     = 32,
   parameter int              UNIT_SHIFT = 23,
   parameter bit              REG_OUT    = 1'b1,
   parameter longint unsigned LO_BASE    = 64'h0008_0000,
   parameter longint unsigned LO_END     = 64'h000A_0000,
   parameter longint unsigned HI_BASE    = 64'h00F0_0000,
   parameter longint unsigned HI_END     = 64'h0100_0000,
   parameter int              SEL_W      = $clog2(NUM_ROWS) + 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [SEL_W-1:0]    wr_addr,
   input  logic [BND_W-1:0]    wr_data,
   input  logic                req_vld,
   input  logic [ADDR_W-1:0]   req_addr,
   output logic                rsp_vld,
   output logic [NUM_ROWS-1:0] row_sel,
   output logic                dram_hit,
   output logic                hole_hit
);

   localparam int UNIT_W = ADDR_W - UNIT_SHIFT;

   // elaboration-time parameter checks
   if (NUM_ROWS < 2 || (NUM_ROWS & (NUM_ROWS - 1)) != 0) begin : g_bad_rows
      $error("NUM_ROWS must be a power of two of at least 2");
   end
   if (UNIT_SHIFT < 1 || UNIT_SHIFT >= ADDR_W) begin : g_bad_shift
      $error("UNIT_SHIFT must lie inside the address");
   end
   if (BND_W < HOLE_CODE_W) begin : g_bad_bnd
      $error("BND_W too narrow to carry the window code");
   end
   if (SEL_W != $clog2(NUM_ROWS) + 1) begin : g_bad_sel
      $error("SEL_W must be one bit wider than the row index");
   end
   if (ADDR_W > 64) begin : g_bad_addr
      $error("ADDR_W above 64 is not supported");
   end

   logic [NUM_ROWS-1:0][BND_W-1:0] bnd;
   hole_mode_e                     hole_mode;
   logic [NUM_ROWS-1:0]            match_sel;
   logic                           match_any;
   logic                           in_hole;
   logic [NUM_ROWS-1:0]            sel_c;
   logic                           hit_c;

   rowbnd_regs #(
      .NUM_ROWS (NUM_ROWS),
      .BND_W    (BND_W),
      .SEL_W    (SEL_W)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .bnd_o   (bnd),
      .hole_o  (hole_mode)
   );

   rowbnd_match #(
      .NUM_ROWS (NUM_ROWS),
      .BND_W    (BND_W),
      .UNIT_W   (UNIT_W)
   ) u_match (
      .unit_i (req_addr[ADDR_W-1:UNIT_SHIFT]),
      .bnd_i  (bnd),
      .sel_o  (match_sel),
      .any_o  (match_any)
   );

   rowbnd_hole #(
      .ADDR_W  (ADDR_W),
      .LO_BASE (LO_BASE),
      .LO_END  (LO_END),
      .HI_BASE (HI_BASE),
      .HI_END  (HI_END)
   ) u_hole (
      .addr_i    (req_addr),
      .mode_i    (hole_mode),
      .in_hole_o (in_hole)
   );

   assign sel_c = in_hole ? '0 : match_sel;
   assign hit_c = match_any && !in_hole;

   if (REG_OUT) begin : g_reg_out
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rsp_vld  <= 1'b0;
            row_sel  <= '0;
            dram_hit <= 1'b0;
            hole_hit <= 1'b0;
         end else begin
            rsp_vld <= req_vld;
            if (req_vld) begin
               row_sel  <= sel_c;
               dram_hit <= hit_c;
               hole_hit <= in_hole;
            end
         end
      end
   end else begin : g_comb_out
      assign rsp_vld  = req_vld;
      assign row_sel  = sel_c;
      assign dram_hit = hit_c;
      assign hole_hit = in_hole;
   end

endmodule

// File: rtl/rowbnd_decoder_chk.sv
`timescale 1ns/1ps
module rowbnd_decoder_chk #(
   parameter int NUM_ROWS = 8,
   parameter int BND_W    = 8,
   parameter int SEL_W    = 4,
   parameter bit REG_OUT  = 1'b1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wr_en,
   input logic [SEL_W-1:0]    wr_addr,
   input logic [BND_W-1:0]    wr_data,
   input logic                req_vld,
   input logic                rsp_vld,
   input logic [NUM_ROWS-1:0] row_sel,
   input logic                dram_hit,
   input logic                hole_hit
);

   localparam logic [SEL_W-1:0] HOLE_IDX = SEL_W'(NUM_ROWS);

   logic       bnd_touched;
   logic [1:0] mode_seen;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bnd_touched <= 1'b0;
         mode_seen   <= 2'b00;
      end else if (wr_en) begin
         if (!wr_addr[SEL_W-1]) bnd_touched <= 1'b1;
         if (wr_addr == HOLE_IDX) mode_seen <= wr_data[1:0];
      end
   end

   // R6
   onehot_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_vld |-> $onehot0(row_sel));

   // R6
   hit_agrees_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_vld |-> (dram_hit == ($countones(row_sel) == 1)));

   // R7
   hole_excludes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_vld && hole_hit) |-> (!dram_hit && row_sel == '0));

   // R1
   fresh_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_vld && !bnd_touched) |-> !dram_hit);

   if (REG_OUT) begin : g_timed
      // R10
      rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
         req_vld |=> rsp_vld);

      // R10
      rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !req_vld |=> !rsp_vld);

      // R9
      no_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (req_vld && (mode_seen == 2'b00 || mode_seen == 2'b11)) |=> !hole_hit);
   end

endmodule

bind rowbnd_decoder rowbnd_decoder_chk #(
   .NUM_ROWS (NUM_ROWS),
   .BND_W    (BND_W),
   .SEL_W    (SEL_W),
   .REG_OUT  (REG_OUT)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_addr  (wr_addr),
   .wr_data  (wr_data),
   .req_vld  (req_vld),
   .rsp_vld  (rsp_vld),
   .row_sel  (row_sel),
   .dram_hit (dram_hit),
   .hole_hit (hole_hit)
);

// File: tb/rowbnd_decoder_test.sv
`timescale 1ns/1ps
module rowbnd_decoder_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        req_vld = 1'b0;
   logic [31:0] req_addr = '0;
   logic        rsp_vld;
   logic [7:0]  row_sel;
   logic        dram_hit;
   logic        hole_hit;

   always #2 clk = ~clk;

   rowbnd_decoder uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .req_vld  (req_vld),
      .req_addr (req_addr),
      .rsp_vld  (rsp_vld),
      .row_sel  (row_sel),
      .dram_hit (dram_hit),
      .hole_hit (hole_hit)
   );

   typedef struct {
      logic [31:0] addr;
      logic [7:0]  sel;
      logic        hit;
      logic        hole;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_checks = 0;
   int   n_fails  = 0;
   bit   finished = 1'b0;

   int         m_bnd[8];
   logic [1:0] m_mode = 2'b00;

   function automatic void predict(input logic [31:0] a, output exp_t e);
      int u;
      u = int'(a >> 23);
      e.addr = a;
      e.sel  = '0;
      e.hole = 1'b0;
      if (m_mode == 2'b01 && a >= 32'h8_0000 && a < 32'hA_0000) e.hole = 1'b1;
      if (m_mode == 2'b10 && a >= 32'hF0_0000 && a < 32'h100_0000) e.hole = 1'b1;
      if (!e.hole) begin
         for (int i = 0; i < 8; i++) begin
            int lo;
            lo = (i == 0) ? 0 : m_bnd[i-1];
            if (e.sel == '0 && u >= lo && u < m_bnd[i]) e.sel = 8'(1 << i);
         end
      end
      e.hit = (e.sel != '0);
   endfunction

   function automatic void model_write(input logic [3:0] a, input logic [7:0] d);
      if (a < 4'd8) m_bnd[a] = int'(d);
      else if (a == 4'd8) m_mode = d[1:0];
   endfunction

   task automatic lookup(input logic [31:0] a, input string tag);
      exp_t e;
      @(negedge clk);
      wr_en    = 1'b0;
      req_vld  = 1'b1;
      req_addr = a;
      predict(a, e);
      e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic wreg(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      req_vld = 1'b0;
      wr_en   = 1'b1;
      wr_addr = a;
      wr_data = d;
      model_write(a, d);
   endtask

   task automatic wreg_and_lookup(input logic [3:0] a, input logic [7:0] d,
                                  input logic [31:0] la, input string tag);
      exp_t e;
      @(negedge clk);
      wr_en    = 1'b1;
      wr_addr  = a;
      wr_data  = d;
      req_vld  = 1'b1;
      req_addr = la;
      predict(la, e);
      e.tag = tag;
      exp_q.push_back(e);
      model_write(a, d);
   endtask

   task automatic idle();
      @(negedge clk);
      wr_en   = 1'b0;
      req_vld = 1'b0;
   endtask

   task automatic all_bnd(input logic [7:0] b0, input logic [7:0] b1,
                          input logic [7:0] b2, input logic [7:0] b3,
                          input logic [7:0] b4, input logic [7:0] b5,
                          input logic [7:0] b6, input logic [7:0] b7);
      wreg(4'd0, b0); wreg(4'd1, b1); wreg(4'd2, b2); wreg(4'd3, b3);
      wreg(4'd4, b4); wreg(4'd5, b5); wreg(4'd6, b6); wreg(4'd7, b7);
   endtask

   // monitor: compare each response against the scoreboard head
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (rst_n && rsp_vld) begin
            n_checks++;
            if (exp_q.size() == 0) begin
               n_fails++;
               $display("FAIL R10 unexpected response row_sel=%b dram_hit=%b hole_hit=%b expected none",
                        row_sel, dram_hit, hole_hit);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               if (row_sel !== e.sel || dram_hit !== e.hit || hole_hit !== e.hole) begin
                  n_fails++;
                  $display("FAIL %s addr=%h row_sel=%b exp %b dram_hit=%b exp %b hole_hit=%b exp %b",
                           e.tag, e.addr, row_sel, e.sel, dram_hit, e.hit, hole_hit, e.hole);
               end
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fails++;
         $display("FAIL watchdog expired, actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 8; i++) m_bnd[i] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: outputs held low in reset
      n_checks++;
      if (rsp_vld !== 1'b0 || row_sel !== 8'h00 || dram_hit !== 1'b0 || hole_hit !== 1'b0) begin
         n_fails++;
         $display("FAIL R1 reset outputs rsp_vld=%b row_sel=%b dram_hit=%b hole_hit=%b expected all 0",
                  rsp_vld, row_sel, dram_hit, hole_hit);
      end
      rst_n = 1'b1;

      // R1: boundaries start at zero
      lookup(32'h0000_0000, "R1");
      lookup(32'h03FF_FFFF, "R1");
      idle();

      // R11: single 64 MB module
      all_bnd(8'h08, 8'h08, 8'h08, 8'h08, 8'h08, 8'h08, 8'h08, 8'h08);
      lookup(32'h0000_0000, "R11");
      lookup(32'h03FF_FFFF, "R11");
      lookup(32'h0400_0000, "R5");
      lookup(32'hFFFF_FFFF, "R5");
      idle();

      // R3 / R4: staggered layout with empty rows 1, 3, 6
      all_bnd(8'd2, 8'd2, 8'd5, 8'd5, 8'd6, 8'd9, 8'd9, 8'd12);
      lookup(32'h00FF_FFFF, "R3");
      lookup(32'h0100_0000, "R4");
      lookup(32'h027F_FFFF, "R3");
      lookup(32'h0280_0000, "R4");
      lookup(32'h0300_0000, "R3");
      lookup(32'h047F_FFFF, "R3");
      lookup(32'h0480_0000, "R4");
      lookup(32'h05FF_FFFF, "R3");
      lookup(32'h0600_0000, "R5");
      idle();

      // R2: unused indices are ignored
      wreg(4'd12, 8'h00);
      wreg(4'd9, 8'h01);
      wreg(4'd15, 8'h00);
      lookup(32'h0280_0000, "R2");
      lookup(32'h0008_0000, "R2");
      lookup(32'h05FF_FFFF, "R2");
      // R2: same-cycle write uses old value, next lookup the new one
      wreg_and_lookup(4'd7, 8'h20, 32'h0600_0000, "R2");
      lookup(32'h0600_0000, "R2");
      idle();

      // R6: unordered boundaries overlap, lowest row wins
      all_bnd(8'd4, 8'd2, 8'd8, 8'd8, 8'd8, 8'd8, 8'd8, 8'd8);
      lookup(32'h0180_0000, "R6");
      lookup(32'h0100_0000, "R6");
      lookup(32'h0280_0000, "R6");
      lookup(32'h0400_0000, "R6");
      idle();

      // R7: low window
      wreg(4'd8, 8'h01);
      lookup(32'h0007_FFFF, "R7");
      lookup(32'h0008_0000, "R7");
      lookup(32'h0009_FFFF, "R7");
      lookup(32'h000A_0000, "R7");
      lookup(32'h00F0_0000, "R7");
      idle();

      // R8: high window
      wreg(4'd8, 8'h02);
      lookup(32'h00EF_FFFF, "R8");
      lookup(32'h00F0_0000, "R8");
      lookup(32'h00FF_FFFF, "R8");
      lookup(32'h0100_0000, "R8");
      lookup(32'h0008_0000, "R8");
      idle();

      // R9: reserved code and no-window code
      wreg(4'd8, 8'h03);
      lookup(32'h0008_0000, "R9");
      lookup(32'h00F0_0000, "R9");
      wreg(4'd8, 8'h00);
      lookup(32'h0009_FFFF, "R9");
      lookup(32'h00FF_FFFF, "R9");
      idle();

      // R7: window reported even with no memory behind it
      all_bnd(8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0);
      wreg(4'd8, 8'h01);
      lookup(32'h0008_0000, "R7");
      idle();

      repeat (4) @(negedge clk);
      // R10: every request answered
      n_checks++;
      if (exp_q.size() != 0) begin
         n_fails++;
         $display("FAIL R10 pending responses actual %0d expected 0", exp_q.size());
      end

      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

endmodule